// File: doc/BRIEF.md
# T1 Receive Signaling Extraction Buffer

This block pulls the robbed-bit signaling out of a received T1 stream and presents it on a backplane as a serial signaling line. The line side shows one channel byte per `rx_valid` beat, together with the channel number and the frame index inside the current multiframe. Only the signaling bit of each beat (`rx_sig_bit`) is taken, and only in the frames that carry signaling. Extraction cannot be switched off. Both superframe (D4, 12 frames) and extended superframe (ESF, 24 frames) multiframes are handled.

Each completed multiframe of per-channel signaling nibbles goes into a ring that holds four multiframes. At every multiframe boundary the oldest ring entry is copied into an output table. A freeze input blocks that copy and keeps the last good table. A serializer walks the backplane frame one bit per `bp_bit_en` strobe and places each channel's nibble in the low four bits of its 8-bit slot. The backplane frame is either 193 bits (1.544 MHz style) or 256 bits (2.048 MHz style).

Top module: `t1sig_extract`

## Requirements
- R1: After reset `sig_out` is 0, and every bit of the next backplane frame is 0 until a later multiframe boundary loads the table.
- R2: ESF mode (`esf_mode`=1) reads A, B, C and D from `rx_sig_bit` in zero-based frames 5, 11, 17 and 23. In each channel slot the transmitted bits 5, 6, 7 and 8 (slot bit indices 4..7, MSB first) carry A, B, C and D.
- R3: D4 mode (`esf_mode`=0) reads A and B in zero-based frames 5 and 11. Slot bits 5, 6, 7 and 8 carry A, B, A and B.
- R4: Beats with `rx_valid` low, and beats in any frame other than the signaling frames, leave the captured signaling unchanged.
- R5: The table loaded at the N-th multiframe boundary after reset holds the signaling of the multiframe that ended at boundary N-4. For N of 4 or less it holds zeros.
- R6: A multiframe boundary is the valid beat of channel 23 in frame 23 (ESF) or frame 11 (D4). Between boundaries the output table does not change, so repeated backplane frames are identical.
- R7: A boundary that occurs while `freeze` is high does not load the table, but the ring still stores that multiframe. The first boundary after release loads normally.
- R8: A narrow frame (`bp_wide`=0) has 193 bits. Bit 0 is a framing position and outputs 0. Channel c occupies bits 1+8c to 8+8c, and the upper four bits of every slot output 0.
- R9: A wide frame (`bp_wide`=1) has 256 bits in 32 slots. Slot c carries channel c for c below 24. Slots 24 to 31, and the upper four bits of every slot, output 0.
- R10: `bp_sync` high with a strobe marks bit 0 of a frame. Without `bp_sync` the bit position wraps to 0 after the last bit of the frame.
- R11: `sig_out` changes only on a clock edge with `bp_bit_en` high. That edge presents the bit for the position of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the line side and the backplane side |
| rst_n | input | 1 | Active-low synchronous reset |
| esf_mode | input | 1 | 1 selects ESF multiframes, 0 selects D4 |
| freeze | input | 1 | Holds the output table at multiframe boundaries |
| rx_valid | input | 1 | Qualifies one received channel beat |
| rx_chan | input | 5 | Channel number of the beat, 0..23 |
| rx_frame | input | 5 | Zero-based frame index within the multiframe |
| rx_sig_bit | input | 1 | Robbed signaling bit of the channel byte |
| bp_wide | input | 1 | 1 selects the 256-bit backplane frame, 0 the 193-bit frame |
| bp_bit_en | input | 1 | Backplane bit strobe |
| bp_sync | input | 1 | Marks bit 0 of the backplane frame |
| sig_out | output | 1 | Serial signaling output |

## Verification
The bench drives fifteen multiframes. Six of them are ESF, two are frozen, one is released, and six are D4 that follow the ESF ones. After each multiframe it reads a backplane frame, alternating narrow and wide, so a design with the wrong ring latency or the wrong freeze handling shows stale or premature nibbles. Garbage bits in non-signaling frames and idle beats would corrupt later nibbles in a design that captured them, and a swapped or missing A/B copy in D4 shows up as mismatched bits 5/7 or 6/8. One wide frame runs without `bp_sync` to catch a counter that does not wrap, and the framing bit and unused wide slots are checked for zero.

// File: rtl/t1sig_pkg.sv
package t1sig_pkg;
   // One channel's signaling nibble: bit 3 = A, bit 2 = B, bit 1 = C, bit 0 = D
   typedef logic [3:0] sig_nib_t;
   localparam int unsigned SLOT_BITS = 8;
endpackage

// File: rtl/t1sig_capture.sv
module t1sig_capture
   import t1sig_pkg::*;
#(
   parameter int unsigned NUM_CH     = 24,
   parameter int unsigned CH_W       = 5,
   parameter int unsigned FRM_W      = 5,
   parameter int unsigned ESF_FRAMES = 24,
   parameter int unsigned D4_FRAMES  = 12,
   parameter int unsigned SIG_PERIOD = 6
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  esf_mode,
   input  logic                  rx_valid,
   input  logic [CH_W-1:0]       rx_chan,
   input  logic [FRM_W-1:0]      rx_frame,
   input  logic                  rx_sig_bit,
   output logic                  mf_done,
   output logic [NUM_CH*4-1:0]   cap_flat
);
   localparam int unsigned ESF_SIGS = ESF_FRAMES / SIG_PERIOD;
   localparam int unsigned D4_SIGS  = D4_FRAMES / SIG_PERIOD;
   localparam logic [FRM_W-1:0] ESF_LAST = FRM_W'(ESF_FRAMES - 1);
   localparam logic [FRM_W-1:0] D4_LAST  = FRM_W'(D4_FRAMES - 1);
   localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);

   if (ESF_SIGS != 4) begin : g_chk_esf
      $error("ESF multiframe must hold four signaling frames");
   end
   if (D4_SIGS != 2) begin : g_chk_d4
      $error("D4 multiframe must hold two signaling frames");
   end
   if ((1 << FRM_W) < ESF_FRAMES) begin : g_chk_frm
      $error("FRM_W too narrow for the ESF frame count");
   end

   logic [FRM_W-1:0] last_frame;
   logic [FRM_W:0]   frame_p1;
   logic             is_sig_frame;
   logic             frame_ok;
   logic [1:0]       sig_idx;
   logic [1:0]       pos_hi;
   logic [1:0]       pos_lo;

   assign last_frame   = esf_mode ? ESF_LAST : D4_LAST;
   assign frame_p1     = {1'b0, rx_frame} + 1'b1;
   assign is_sig_frame = ((frame_p1 % SIG_PERIOD) == 0);
   assign frame_ok     = (rx_frame <= last_frame);
   assign sig_idx      = 2'((frame_p1 / SIG_PERIOD) - 1);
   assign pos_hi       = 2'(2'd3 - sig_idx);
   assign pos_lo       = 2'(2'd1 - sig_idx);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      sig_nib_t nib_q;
      logic     hit;
      assign hit = rx_valid && (rx_chan == CH_W'(ch)) && is_sig_frame && frame_ok;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            nib_q <= '0;
         end else if (hit) begin
            if (esf_mode) begin
               nib_q[pos_hi] <= rx_sig_bit;
            end else if (!sig_idx[1]) begin
               nib_q[pos_hi] <= rx_sig_bit;
               nib_q[pos_lo] <= rx_sig_bit;
            end
         end
      end
      assign cap_flat[ch*4 +: 4] = nib_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mf_done <= 1'b0;
      else        mf_done <= rx_valid && (rx_chan == LAST_CH) && (rx_frame == last_frame);
   end

   // R4: a cycle without a valid beat never alters the captured nibbles
   a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> $stable(cap_flat));
endmodule

// File: rtl/t1sig_mfbuf.sv
module t1sig_mfbuf #(
   parameter int unsigned NUM_CH   = 24,
   parameter int unsigned MF_DEPTH = 4
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  push,
   input  logic                  freeze,
   input  logic [NUM_CH*4-1:0]   cap_flat,
   output logic [NUM_CH*4-1:0]   tab_flat
);
   localparam int unsigned TAB_W = NUM_CH * 4;
   localparam int unsigned PTR_W = (MF_DEPTH > 1) ? $clog2(MF_DEPTH) : 1;

   if (MF_DEPTH < 2) begin : g_chk_depth
      $error("MF_DEPTH must be at least 2");
   end

   logic [TAB_W-1:0] ring_q [MF_DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] ptr_next;

   if ((1 << PTR_W) == MF_DEPTH) begin : g_pow2
      assign ptr_next = wr_ptr + 1'b1;
   end else begin : g_wrap
      assign ptr_next = (wr_ptr == PTR_W'(MF_DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < MF_DEPTH; i++) ring_q[i] <= '0;
         wr_ptr   <= '0;
         tab_flat <= '0;
      end else if (push) begin
         ring_q[wr_ptr] <= cap_flat;
         wr_ptr         <= ptr_next;
         if (!freeze) tab_flat <= ring_q[wr_ptr];
      end
   end

   // R6: table is only refreshed at a boundary
   a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !push |=> $stable(tab_flat));
   // R7: a frozen boundary keeps the previous table
   a_r7_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
      push && freeze |=> $stable(tab_flat));
   // R5: every boundary advances the ring, frozen or not
   a_r5_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> wr_ptr != $past(wr_ptr));
endmodule

// File: rtl/t1sig_bpser.sv
module t1sig_bpser
   import t1sig_pkg::*;
#(
   parameter int unsigned NUM_CH     = 24,
   parameter int unsigned WIDE_SLOTS = 32
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bp_wide,
   input  logic                  bp_bit_en,
   input  logic                  bp_sync,
   input  logic [NUM_CH*4-1:0]   tab_flat,
   output logic                  sig_out
);
   localparam int unsigned NARROW_LEN = 1 + NUM_CH * SLOT_BITS;
   localparam int unsigned WIDE_LEN   = WIDE_SLOTS * SLOT_BITS;
   localparam int unsigned MAX_LEN    = (WIDE_LEN > NARROW_LEN) ? WIDE_LEN : NARROW_LEN;
   localparam int unsigned CNT_W      = $clog2(MAX_LEN + 1);
   localparam int unsigned SLOT_W     = $clog2(WIDE_SLOTS);

   if (WIDE_SLOTS < NUM_CH) begin : g_chk_slots
      $error("wide frame must have a slot for every channel");
   end

   logic [CNT_W-1:0]  bit_cnt;
   logic [CNT_W-1:0]  pos;
   logic [CNT_W-1:0]  pos_next;
   logic [CNT_W-1:0]  frame_len;
   logic [CNT_W-1:0]  body_pos;
   logic              in_body;
   logic [SLOT_W-1:0] slot;
   logic [2:0]        bit_in_slot;
   sig_nib_t          nib;
   logic              bit_val;

   assign frame_len   = bp_wide ? CNT_W'(WIDE_LEN) : CNT_W'(NARROW_LEN);
   assign pos         = bp_sync ? '0 : bit_cnt;
   assign pos_next    = (pos == frame_len - 1'b1) ? '0 : pos + 1'b1;
   assign in_body     = bp_wide || (pos != '0);
   assign body_pos    = bp_wide ? pos : pos - 1'b1;
   assign slot        = SLOT_W'(body_pos >> 3);
   assign bit_in_slot = 3'(body_pos);
   assign nib         = (slot < SLOT_W'(NUM_CH)) ? sig_nib_t'(tab_flat >> {slot, 2'b00}) : '0;
   assign bit_val     = in_body && bit_in_slot[2] && nib[2'(2'd3 - bit_in_slot[1:0])];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         sig_out <= 1'b0;
      end else if (bp_bit_en) begin
         bit_cnt <= pos_next;
         sig_out <= bit_val;
      end
   end

   // R10: a sync strobe restarts the frame at bit 0
   a_r10_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
      bp_bit_en && bp_sync |=> bit_cnt == CNT_W'(1));
   // R11: output only moves on a strobe
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bp_bit_en |=> $stable(sig_out));
   // R8: narrow framing position outputs zero
   a_r8_fbit_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bp_bit_en && !bp_wide && bp_sync |=> !sig_out);
   // R9: wide slots beyond the last channel output zero
   a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bp_bit_en && bp_wide && !bp_sync && (bit_cnt >= CNT_W'(NUM_CH * SLOT_BITS)) |=> !sig_out);
endmodule

// File: rtl/t1sig_extract.sv
module t1sig_extract #(
   parameter int unsigned NUM_CH     = 24,
   parameter int unsigned CH_W       = 5,
   parameter int unsigned FRM_W      = 5,
   parameter int unsigned MF_DEPTH   = 4,
   parameter int unsigned WIDE_SLOTS = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             esf_mode,
   input  logic             freeze,
   input  logic             rx_valid,
   input  logic [CH_W-1:0]  rx_chan,
   input  logic [FRM_W-1:0] rx_frame,
   input  logic             rx_sig_bit,
   input  logic             bp_wide,
   input  logic             bp_bit_en,
   input  logic             bp_sync,
   output logic             sig_out
);
   localparam int unsigned TAB_W = NUM_CH * 4;

   if ((1 << CH_W) < NUM_CH) begin : g_chk_ch
      $error("CH_W too narrow for NUM_CH");
   end

   logic             mf_done;
   logic [TAB_W-1:0] cap_flat;
   logic [TAB_W-1:0] tab_flat;

   t1sig_capture #(
      .NUM_CH(NUM_CH), .CH_W(CH_W), .FRM_W(FRM_W),
      .ESF_FRAMES(24), .D4_FRAMES(12), .SIG_PERIOD(6)
   ) u_capture (
      .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .rx_valid(rx_valid),
      .rx_chan(rx_chan), .rx_frame(rx_frame), .rx_sig_bit(rx_sig_bit),
      .mf_done(mf_done), .cap_flat(cap_flat)
   );

   t1sig_mfbuf #(.NUM_CH(NUM_CH), .MF_DEPTH(MF_DEPTH)) u_mfbuf (
      .clk(clk), .rst_n(rst_n), .push(mf_done), .freeze(freeze),
      .cap_flat(cap_flat), .tab_flat(tab_flat)
   );

   t1sig_bpser #(.NUM_CH(NUM_CH), .WIDE_SLOTS(WIDE_SLOTS)) u_bpser (
      .clk(clk), .rst_n(rst_n), .bp_wide(bp_wide), .bp_bit_en(bp_bit_en),
      .bp_sync(bp_sync), .tab_flat(tab_flat), .sig_out(sig_out)
   );
endmodule

// File: tb/t1sig_extract_bench.sv
module t1sig_extract_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       esf_mode = 1'b1;
   logic       freeze = 1'b0;
   logic       rx_valid = 1'b0;
   logic [4:0] rx_chan = '0;
   logic [4:0] rx_frame = '0;
   logic       rx_sig_bit = 1'b0;
   logic       bp_wide = 1'b0;
   logic       bp_bit_en = 1'b0;
   logic       bp_sync = 1'b0;
   logic       sig_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct { bit v; string req; } exp_t;
   exp_t exp_q[$];

   logic [3:0] model_tab [24];
   logic [3:0] mf_nib [0:20][24];
   bit last_exp;

   always #2 clk = ~clk;

   t1sig_extract u_t1sig_extract (
      .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .freeze(freeze),
      .rx_valid(rx_valid), .rx_chan(rx_chan), .rx_frame(rx_frame),
      .rx_sig_bit(rx_sig_bit), .bp_wide(bp_wide), .bp_bit_en(bp_bit_en),
      .bp_sync(bp_sync), .sig_out(sig_out)
   );

   task automatic check(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   function automatic bit pat(int m, int ch, int k);
      return ((m * 13 + ch * 7 + k * 11 + ch * m) % 5) < 2;
   endfunction

   // Expected bit from the requirements (R8, R9, R2, R3)
   function automatic bit ebit(bit wide, int pos);
      int p, s, b;
      if (!wide && pos == 0) return 1'b0;
      p = wide ? pos : pos - 1;
      s = p / 8;
      b = p % 8;
      if (s >= 24 || b < 4) return 1'b0;
      return model_tab[s][7 - b];
   endfunction

   // Drive one multiframe of line beats, with idle gaps and garbage (R4)
   task automatic run_mf(int m, bit esf, bit frz);
      int nfr = esf ? 24 : 12;
      int beat = 0;
      @(negedge clk);
      esf_mode = esf;
      freeze = frz;
      for (int f = 0; f < nfr; f++) begin
         for (int ch = 0; ch < 24; ch++) begin
            @(negedge clk);
            if (beat % 7 == 3) begin
               rx_valid = 1'b0;
               rx_chan = 5'(ch);
               rx_frame = 5'd5;
               rx_sig_bit = ~pat(m, ch, 0);
               @(negedge clk);
            end
            rx_valid = 1'b1;
            rx_chan = 5'(ch);
            rx_frame = 5'(f);
            if ((f + 1) % 6 == 0) rx_sig_bit = pat(m, ch, (f + 1) / 6 - 1);
            else rx_sig_bit = 1'(((ch + f) & 1) ^ 1);
            beat++;
         end
      end
      @(negedge clk);
      rx_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      for (int ch = 0; ch < 24; ch++) begin
         if (esf) mf_nib[m][ch] = {pat(m,ch,0), pat(m,ch,1), pat(m,ch,2), pat(m,ch,3)};
         else     mf_nib[m][ch] = {pat(m,ch,0), pat(m,ch,1), pat(m,ch,0), pat(m,ch,1)};
      end
      if (!frz) begin
         for (int ch = 0; ch < 24; ch++) model_tab[ch] = (m > 4) ? mf_nib[m-4][ch] : 4'h0;
      end
   endtask

   // Scoreboard driver: play a backplane frame, pushing the expected bits
   task automatic play_bp(bit wide, bit sync, string req);
      int len = wide ? 256 : 193;
      for (int pos = 0; pos < len; pos++) begin
         exp_t e;
         @(negedge clk);
         bp_wide = wide;
         bp_bit_en = 1'b1;
         bp_sync = sync && (pos == 0);
         e.v = ebit(wide, pos);
         if (!wide && pos == 0) e.req = "R8";
         else if (wide && pos >= 192) e.req = "R9";
         else e.req = req;
         last_exp = e.v;
         exp_q.push_back(e);
      end
      @(negedge clk);
      bp_bit_en = 1'b0;
      bp_sync = 1'b0;
      repeat (3) @(negedge clk);
      // R11: output holds while no strobe arrives
      check(sig_out === last_exp, "R11", int'(sig_out), int'(last_exp));
   endtask

   // Scoreboard monitor
   always @(posedge clk) begin : mon
      logic en_s;
      exp_t e;
      en_s = bp_bit_en;
      #1;
      if (en_s && rst_n) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R11", int'(sig_out), -1);
         end else begin
            e = exp_q.pop_front();
            check(sig_out === e.v, e.req, int'(sig_out), int'(e.v));
         end
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin : main
      for (int ch = 0; ch < 24; ch++) model_tab[ch] = 4'h0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(sig_out === 1'b0, "R1", int'(sig_out), 0);
      play_bp(1'b0, 1'b1, "R1");

      for (int m = 1; m <= 6; m++) begin
         run_mf(m, 1'b1, 1'b0);
         play_bp(1'(m % 2), 1'b1, (m <= 5) ? "R5" : "R2");
         if (m == 5) play_bp(1'b1, 1'b0, "R10");
      end

      for (int m = 7; m <= 8; m++) begin
         run_mf(m, 1'b1, 1'b1);
         play_bp(1'b0, 1'b1, "R7");
      end
      run_mf(9, 1'b1, 1'b0);
      play_bp(1'b1, 1'b1, "R7");

      for (int m = 10; m <= 15; m++) begin
         run_mf(m, 1'b0, 1'b0);
         play_bp(1'(m % 2), 1'b1, (m >= 14) ? "R3" : "R4");
      end
      play_bp(1'b0, 1'b1, "R6");

      done = 1;
      summary();
      $finish;
   end
endmodule